// File: doc/BRIEF.md
# Three-Register Stack Accumulator Unit

This block is a fixed-point arithmetic engine built around three registers that software cannot address directly. I is the top of a two-deep operand stack, J sits beneath it, and O is an accumulator. Words come in only by being pushed into I, and the old I drops into J on every push. Results leave only from O, through a store command that can either keep O or clear it once the value has been taken.

An operation command combines I and J and, for the arithmetic sub-codes, adds the result to the current O. Copy sub-codes overwrite O with I or with J. One sub-code picks I or J from the sign of O. Multiply is sequential: it holds `busy` for W cycles, then adds the rounded product into O. Data words are W-bit two's-complement fractions (default 31 bits) in the range -1 <= x < 1, with the binary point just below the sign bit. Sums wrap modulo 2^W and no overflow is flagged. Sub-codes that have no datapath here are accepted, change nothing, and raise a one-cycle `unsup` pulse.

Control is a two-state machine. In ST_IDLE the unit accepts one command per cycle. An accepted multiply takes the transition IDLE->MUL. In ST_MUL every command is ignored, and the transition MUL->IDLE fires on the edge where the last partial product is added and O is updated.

Top module: `sau_stack_alu`

## Requirements
- R1: After reset, O, I and J are zero, `busy`, `unsup` and `store_valid` are low, and the state is ST_IDLE.
- R2: An accepted push loads `push_data` into I and moves the previous I into J on the same edge.
- R3: Sub-code 0 sets O to O+I+J, sub-code 1 sets O to O+I-J, and sub-code 4 sets O to O+I. All three wrap modulo 2^W and update O on the accepting edge.
- R4: Sub-code 5 overwrites O with I, and sub-code 6 overwrites O with J.
- R5: Sub-code 7 overwrites O with I when O's sign bit is 0, and with J when it is 1.
- R6: Sub-code 2 forms the fractional product I*J as bits [2W-2:W-1] of the full 2W-bit signed product. If any lower bit is nonzero, bit 0 of the result is forced to 1 (rounding to odd). The result is added to O. `busy` is high for exactly W cycles after the accepting edge, O stays unchanged while `busy` is high, and O is updated on the edge where `busy` falls.
- R7: While `busy` is high, every command (op, push, move, store) is ignored.
- R8: When several commands are presented in one idle cycle, only one executes, with priority op > push > move > store.
- R9: A move copies O into I and pushes the old I into J.
- R10: An accepted store presents O on `store_data` with `store_valid` high for one cycle after the edge. `store_keep`=0 clears O on that edge, and `store_keep`=1 retains O.
- R11: Sub-codes 3 and 8 to 15 leave O, I and J unchanged and raise `unsup` for one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation command |
| op_code | input | 4 | Operation sub-code |
| push_valid | input | 1 | Push command |
| push_data | input | W | Word pushed into I |
| move_req | input | 1 | Copy O into I (push) |
| store_req | input | 1 | Store command |
| store_keep | input | 1 | 1 retains O after store, 0 clears it |
| busy | output | 1 | Multiply in progress (state ST_MUL) |
| unsup | output | 1 | One-cycle unsupported sub-code pulse |
| o_value | output | W | Current accumulator O |
| store_valid | output | 1 | Store result valid |
| store_data | output | W | Value of O taken by the store |

## Verification
I and J are not visible at the ports. A wrong stack value therefore shows up only when a later copy, sum or sign-select moves it into O, which is usually a few commands after the fault. A wrong accumulator or control state shows on `o_value`, `busy` or `unsup` at the very next clock edge. For that reason the bench runs a behavioural model next to the design and compares every output on every cycle, and it drives copy sub-codes after each push and move pattern to bring the hidden registers out. Multiply timing errors show up as `busy` mismatching in the window of W cycles, or as O changing one edge early or late.

// File: rtl/sau_pkg.sv
package sau_pkg;
    localparam int unsigned OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD2  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_SUB2  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_MUL   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_CPYI  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_CPYJ  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_SGNSEL = 4'd7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MUL  = 1'b1
    } sau_state_e;
endpackage

// File: rtl/sau_alu.sv
module sau_alu
    import sau_pkg::*;
#(
    parameter int unsigned W = 31
) (
    input  logic [OPC_W-1:0] code,
    input  logic [W-1:0]     i_val,
    input  logic [W-1:0]     j_val,
    input  logic [W-1:0]     o_val,
    output logic [W-1:0]     o_next,
    output logic             o_write,
    output logic             is_mul,
    output logic             is_unsup
);
    always_comb begin
        o_next   = o_val;
        o_write  = 1'b0;
        is_mul   = 1'b0;
        is_unsup = 1'b0;
        case (code)
            OPC_ADD2:   begin o_next = o_val + i_val + j_val; o_write = 1'b1; end
            OPC_SUB2:   begin o_next = o_val + i_val - j_val; o_write = 1'b1; end
            OPC_ADDI:   begin o_next = o_val + i_val;         o_write = 1'b1; end
            OPC_CPYI:   begin o_next = i_val;                 o_write = 1'b1; end
            OPC_CPYJ:   begin o_next = j_val;                 o_write = 1'b1; end
            OPC_SGNSEL: begin o_next = o_val[W-1] ? j_val : i_val; o_write = 1'b1; end
            OPC_MUL:    is_mul = 1'b1;
            default:    is_unsup = 1'b1;
        endcase
    end
endmodule

// File: rtl/sau_mult.sv
module sau_mult #(
    parameter int unsigned W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         done,
    output logic [W-1:0] prod
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          run;
    logic [CW-1:0] cnt;
    logic [PW-1:0] mcand;
    logic [W-1:0]  mplier;
    logic [PW-1:0] acc;
    logic [PW-1:0] part;
    logic [PW-1:0] acc_sum;
    logic          last;
    logic [W-1:0]  hi;
    logic          sticky;

    assign last = (cnt == LAST);

    always_comb begin
        part = '0;
        if (mplier[0]) begin
            part = last ? (~mcand + 1'b1) : mcand;
        end
        acc_sum = acc + part;
        hi      = acc_sum[PW-2:W-1];
        sticky  = |acc_sum[W-2:0];
        prod    = {hi[W-1:1], hi[0] | sticky};
        done    = run && last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt    <= '0;
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
        end else if (start) begin
            run    <= 1'b1;
            cnt    <= '0;
            acc    <= '0;
            mcand  <= {{W{a[W-1]}}, a};
            mplier <= b;
        end else if (run) begin
            acc    <= acc_sum;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt + 1'b1;
            if (last) begin
                run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sau_stack_alu.sv
module sau_stack_alu
    import sau_pkg::*;
#(
    parameter int unsigned W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic             push_valid,
    input  logic [W-1:0]     push_data,
    input  logic             move_req,
    input  logic             store_req,
    input  logic             store_keep,
    output logic             busy,
    output logic             unsup,
    output logic [W-1:0]     o_value,
    output logic             store_valid,
    output logic [W-1:0]     store_data
);
    sau_state_e state_q, state_d;

    logic [W-1:0] i_q, j_q, o_q, sd_q;
    logic         unsup_q, sv_q;

    logic [W-1:0] alu_o;
    logic         alu_wr, alu_mul, alu_unsup;
    logic         mul_done;
    logic [W-1:0] mul_prod;

    logic idle, do_op, do_push, do_move, do_store, mul_start;

    assign idle      = (state_q == ST_IDLE);
    assign do_op     = idle && op_valid;
    assign do_push   = idle && !op_valid && push_valid;
    assign do_move   = idle && !op_valid && !push_valid && move_req;
    assign do_store  = idle && !op_valid && !push_valid && !move_req && store_req;
    assign mul_start = do_op && alu_mul;

    sau_alu #(.W(W)) u_alu (
        .code     (op_code),
        .i_val    (i_q),
        .j_val    (j_q),
        .o_val    (o_q),
        .o_next   (alu_o),
        .o_write  (alu_wr),
        .is_mul   (alu_mul),
        .is_unsup (alu_unsup)
    );

    sau_mult #(.W(W)) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (i_q),
        .b     (j_q),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (mul_start) state_d = ST_MUL;
            ST_MUL:  if (mul_done)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q     <= '0;
            j_q     <= '0;
            o_q     <= '0;
            sd_q    <= '0;
            unsup_q <= 1'b0;
            sv_q    <= 1'b0;
        end else begin
            unsup_q <= 1'b0;
            sv_q    <= 1'b0;
            if (state_q == ST_MUL) begin
                if (mul_done) begin
                    o_q <= o_q + mul_prod;
                end
            end else if (do_op) begin
                if (alu_wr) begin
                    o_q <= alu_o;
                end
                unsup_q <= alu_unsup;
            end else if (do_push) begin
                i_q <= push_data;
                j_q <= i_q;
            end else if (do_move) begin
                i_q <= o_q;
                j_q <= i_q;
            end else if (do_store) begin
                sd_q <= o_q;
                sv_q <= 1'b1;
                if (!store_keep) begin
                    o_q <= '0;
                end
            end
        end
    end

    always_comb begin
        busy        = (state_q == ST_MUL);
        unsup       = unsup_q;
        o_value     = o_q;
        store_valid = sv_q;
        store_data  = sd_q;
    end
endmodule

// File: rtl/sau_checker.sv
module sau_checker #(
    parameter int unsigned W = 31
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic         push_valid,
    input logic         move_req,
    input logic         store_req,
    input logic         store_keep,
    input logic         busy,
    input logic         unsup,
    input logic [W-1:0] o_value,
    input logic         store_valid,
    input logic [W-1:0] store_data
);
    logic st_only;
    logic code_bad;
    assign st_only  = store_req && !op_valid && !push_valid && !move_req && !busy;
    assign code_bad = (op_code == 4'd3) || (op_code >= 4'd8);

    AST_STORE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        st_only |=> (store_valid && store_data == $past(o_value))); // R10
    AST_STORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_only && !store_keep) |=> (o_value == '0)); // R10
    AST_MUL_HOLD_O: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(o_value)); // R6
    AST_MUL_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 4'd2) |=> busy); // R6
    AST_UNSUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        unsup |-> $past(op_valid && !busy && code_bad)); // R11
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!store_valid && !unsup)); // R7
endmodule

bind sau_stack_alu sau_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .push_valid  (push_valid),
    .move_req    (move_req),
    .store_req   (store_req),
    .store_keep  (store_keep),
    .busy        (busy),
    .unsup       (unsup),
    .o_value     (o_value),
    .store_valid (store_valid),
    .store_data  (store_data)
);

// File: tb/sau_stack_alu_tb.sv
module sau_stack_alu_tb;
    localparam int W = 31;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic         push_valid = 1'b0;
    logic [W-1:0] push_data = '0;
    logic         move_req = 1'b0;
    logic         store_req = 1'b0;
    logic         store_keep = 1'b0;
    logic         busy, unsup, store_valid;
    logic [W-1:0] o_value, store_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur = "R1";
    bit    run_cmp = 1'b0;

    logic [W-1:0] mi, mj, mo, msd, mprod;
    bit           munsup, msv;
    int           mcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    sau_stack_alu #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .push_valid(push_valid), .push_data(push_data), .move_req(move_req),
        .store_req(store_req), .store_keep(store_keep), .busy(busy),
        .unsup(unsup), .o_value(o_value), .store_valid(store_valid),
        .store_data(store_data)
    );

    function automatic logic [W-1:0] frac_mul(logic [W-1:0] a, logic [W-1:0] b);
        longint p, r;
        logic [W-1:0] res;
        p = longint'($signed(a)) * longint'($signed(b));
        r = p >>> (W - 1);
        res = r[W-1:0];
        if (p[W-2:0] != '0) res[0] = 1'b1;
        return res;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            mi = '0; mj = '0; mo = '0; msd = '0; mprod = '0;
            munsup = 0; msv = 0; mcnt = 0;
        end else begin
            munsup = 0;
            msv = 0;
            if (mcnt > 0) begin
                mcnt = mcnt - 1;
                if (mcnt == 0) mo = mo + mprod;
            end else if (op_valid) begin
                case (op_code)
                    4'd0: mo = mo + mi + mj;
                    4'd1: mo = mo + mi - mj;
                    4'd2: begin mprod = frac_mul(mi, mj); mcnt = W; end
                    4'd4: mo = mo + mi;
                    4'd5: mo = mi;
                    4'd6: mo = mj;
                    4'd7: mo = mo[W-1] ? mj : mi;
                    default: munsup = 1;
                endcase
            end else if (push_valid) begin
                mj = mi; mi = push_data;
            end else if (move_req) begin
                mj = mi; mi = mo;
            end else if (store_req) begin
                msd = mo; msv = 1;
                if (!store_keep) mo = '0;
            end
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("o_value", 64'(o_value), 64'(mo));
            chk("busy", 64'(busy), 64'(mcnt > 0));
            chk("unsup", 64'(unsup), 64'(munsup));
            chk("store_valid", 64'(store_valid), 64'(msv));
            if (msv) chk("store_data", 64'(store_data), 64'(msd));
        end
    end

    task automatic issue(bit ov, logic [3:0] oc, bit pv, logic [W-1:0] pd,
                         bit mv, bit sv, bit kp);
        @(negedge clk);
        op_valid = ov; op_code = oc; push_valid = pv; push_data = pd;
        move_req = mv; store_req = sv; store_keep = kp;
        @(negedge clk);
        op_valid = 0; push_valid = 0; move_req = 0; store_req = 0;
    endtask

    task automatic op(logic [3:0] c);           issue(1, c, 0, '0, 0, 0, 0); endtask
    task automatic push(logic [W-1:0] d);       issue(0, '0, 1, d, 0, 0, 0); endtask
    task automatic move();                      issue(0, '0, 0, '0, 1, 0, 0); endtask
    task automatic store(bit kp);               issue(0, '0, 0, '0, 0, 1, kp); endtask
    task automatic wait_cyc(int n);             repeat (n) @(negedge clk); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur = "R1";
        chk("reset o_value", 64'(o_value), 64'd0);
        chk("reset busy", 64'(busy), 64'd0);
        chk("reset unsup", 64'(unsup), 64'd0);
        chk("reset store_valid", 64'(store_valid), 64'd0);
        run_cmp = 1'b1;
        op(4'd5); op(4'd6);                        // R1 stack zero after reset

        cur = "R2";
        push(31'd100); push(31'd200);
        op(4'd5); op(4'd6);

        cur = "R3";
        op(4'd0); op(4'd1); op(4'd4);
        push(31'h3FFF_FFFF); op(4'd4); op(4'd4);   // wrap
        op(4'd1);

        cur = "R4";
        op(4'd5); op(4'd6);

        cur = "R5";
        store(1'b0);
        op(4'd7);                                  // O positive -> I
        push(31'h4000_0000); op(4'd5); op(4'd7);   // O negative -> J

        cur = "R6";
        push(31'h2000_0000); push(31'h2000_0000); store(0); op(4'd2); wait_cyc(W + 2);
        push(31'd3); push(31'd3); op(4'd2); wait_cyc(W + 2);
        push(31'h7FFF_FFFD); push(31'd3); op(4'd2); wait_cyc(W + 2);
        push(31'h4000_0000); push(31'h4000_0000); op(4'd2); wait_cyc(W + 2);
        push(31'h6000_0000); push(31'h5555_5555); op(4'd2); wait_cyc(W + 2);

        cur = "R7";
        push(31'd7); push(31'd9); op(4'd2);
        push(31'd55); move(); store(0); op(4'd5); op(4'd0);
        wait_cyc(W);
        op(4'd5); op(4'd6);

        cur = "R8";
        issue(1, 4'd4, 1, 31'd11, 1, 1, 0);
        issue(0, 4'd0, 1, 31'd12, 1, 1, 0);
        issue(0, 4'd0, 0, 31'd0, 1, 1, 0);
        op(4'd5); op(4'd6);

        cur = "R9";
        push(31'd42); op(4'd5); op(4'd4); move(); op(4'd5); op(4'd6);

        cur = "R10";
        store(1'b1); store(1'b1); store(1'b0); store(1'b1);

        cur = "R11";
        push(31'd5); op(4'd5);
        op(4'd3); op(4'd8); op(4'd9); op(4'd15);
        op(4'd5); op(4'd6);

        cur = "R3 R6 R9 R10 mixed";
        lcg = 32'h1234_5678;
        for (int k = 0; k < 300; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            case (lcg[31:29])
                3'd0, 3'd1: push(lcg[W-1:0] ^ {lcg[7:0], 23'd0});
                3'd2: move();
                3'd3: store(lcg[5]);
                default: begin
                    op(lcg[11:8]);
                    if (busy) wait_cyc(W);
                end
            endcase
        end
        wait_cyc(W + 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule